// File: doc/BRIEF.md
# Masked Lowest-Bit Manipulation Unit

This block is a purely combinational datapath slice that rewrites an XLEN-bit operand using one of a family of lowest-set-bit and lowest-clear-bit idioms, confined to a bit mask. A 5-bit mode word sets three things: whether the masked operand is inverted, which arithmetic neighbour of the operand is formed, and how the two resulting terms are merged. Typical uses include isolating the lowest set bit, clearing the lowest set bit, setting the lowest clear bit and building trailing-zero masks. Each of these runs on the whole word or on a chosen field of it.

The mask is taken from the second operand unless the caller reports that the second register field is zero. In that case the whole word is active. After the two terms are merged, the result is cut back to the mask. A restore flag can then merge the untouched bits of the first operand back into the result, so that a field can be edited in place. Register-field decode is done outside the block.

Top module: `masked_bit_manip`

## Requirements
- R1: The active mask is all ones when `b_is_zero` is 1, and equals `opb` when `b_is_zero` is 0.
- R2: Bits of `opa` outside the mask have no effect on the result bits inside the mask. The working value is w = `opa` & mask.
- R3: Mode bit 0 selects the first term. A value of 1 gives w, and a value of 0 gives NOT w.
- R4: Mode bits [2:1] select the second term. Code 0 gives NOT w + 1, code 1 gives w - 1, code 2 gives w + 1, and code 3 gives NOT (w + 1).
- R5: All second-term arithmetic wraps modulo 2^XLEN. For example, w = 0 with code 1 gives all ones before masking.
- R6: Both terms are ANDed with the mask before they are merged.
- R7: Mode bits [4:3] select the merge operator. Code 0 is OR, code 1 is AND and code 2 is XOR.
- R8: Merge code 3 yields zero on every bit inside the mask.
- R9: With `restore` at 0, every result bit outside the mask is 0.
- R10: With `restore` at 1, every result bit outside the mask equals the matching bit of `opa`.
- R11: Mode 5'b01001 isolates the lowest set bit of w. Mode 5'b01011 clears the lowest set bit of w. Mode 5'b00101 sets the lowest clear bit of w.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | XLEN | Operand to manipulate |
| opb | input | XLEN | Mask operand |
| b_is_zero | input | 1 | Second register field was zero: use a full mask |
| mode | input | 5 | Mode word: bit 0 selects inversion, [2:1] select the neighbour, [4:3] select the merge |
| restore | input | 1 | Merge the bits of `opa` outside the mask back into the result |
| result | output | XLEN | Manipulated word |

## Verification
The block holds no state, so a wrong internal term or a wrong mask shows on `result` in the same cycle as the stimulus that exposes it. A wrong term decode or a missing wrap shows only on words whose low bits hit the carry or borrow boundary. For that reason the directed vectors place the lowest set bit at several positions and include all-zero and all-ones words. Mask faults show up as leaked or lost bits outside the field, so the random vectors mix contiguous masks, sparse masks and the full mask, each with and without restore.

// File: rtl/mbm_pkg.sv
// Package: shared encodings for the masked lowest-bit manipulation unit.
// Assumes the mode word layout {merge[1:0], neighbour[1:0], pass_plain}.
package mbm_pkg;

    localparam int MODE_W   = 5;
    localparam int PLAIN_B  = 0;
    localparam int NBR_LO   = 1;
    localparam int MERGE_LO = 3;

    typedef enum logic [1:0] {
        NBR_NEG     = 2'd0,
        NBR_DEC     = 2'd1,
        NBR_INC     = 2'd2,
        NBR_NOT_INC = 2'd3
    } nbr_sel_e;

    typedef enum logic [1:0] {
        MERGE_OR   = 2'd0,
        MERGE_AND  = 2'd1,
        MERGE_XOR  = 2'd2,
        MERGE_NONE = 2'd3
    } merge_sel_e;

endpackage

// File: rtl/mbm_mask_gen.sv
// Module: mbm_mask_gen
// Forms the active mask and the masked working value.
// Assumes the caller has already decoded whether the mask register field is zero.
module mbm_mask_gen #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            b_is_zero,
    output logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] work
);

    // Pick the full mask or the operand mask, then restrict the operand to it.
    always_comb begin
        mask = b_is_zero ? {XLEN{1'b1}} : opb;
        work = opa & mask;
    end

endmodule

// File: rtl/mbm_term_gen.sv
// Module: mbm_term_gen
// Builds the two masked terms from the working value.
// Assumes work is already confined to the mask; arithmetic wraps at XLEN bits.
module mbm_term_gen #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]       work,
    input  logic [XLEN-1:0]       mask,
    input  logic                  pass_plain,
    input  mbm_pkg::nbr_sel_e     nbr_sel,
    output logic [XLEN-1:0]       term_a,
    output logic [XLEN-1:0]       term_b
);
    import mbm_pkg::*;

    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] inc_w;
    logic [XLEN-1:0] nbr;

    // Shared incrementer for the two increment-based neighbours.
    always_comb inc_w = work + ONE;

    // Choose the arithmetic neighbour of the working value.
    always_comb begin
        unique case (nbr_sel)
            NBR_NEG:     nbr = ~work + ONE;
            NBR_DEC:     nbr = work - ONE;
            NBR_INC:     nbr = inc_w;
            NBR_NOT_INC: nbr = ~inc_w;
            default:     nbr = '0;
        endcase
    end

    // Apply optional inversion to the first term and mask both terms.
    always_comb begin
        term_a = (pass_plain ? work : ~work) & mask;
        term_b = nbr & mask;
    end

endmodule

// File: rtl/mbm_merge.sv
// Module: mbm_merge
// Merges the two terms, trims to the mask and optionally restores outside bits.
// Assumes the terms are already masked; merge code 3 produces zero by choice.
module mbm_merge #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]    term_a,
    input  logic [XLEN-1:0]    term_b,
    input  logic [XLEN-1:0]    mask,
    input  logic [XLEN-1:0]    opa,
    input  mbm_pkg::merge_sel_e merge_sel,
    input  logic               restore,
    output logic [XLEN-1:0]    result
);
    import mbm_pkg::*;

    logic [XLEN-1:0] merged;

    // Select the merge operator.
    always_comb begin
        unique case (merge_sel)
            MERGE_OR:   merged = term_a | term_b;
            MERGE_AND:  merged = term_a & term_b;
            MERGE_XOR:  merged = term_a ^ term_b;
            MERGE_NONE: merged = '0;
            default:    merged = '0;
        endcase
    end

    // Trim to the mask and bring back the outside bits of opa on request.
    always_comb begin
        result = (merged & mask) | (restore ? (opa & ~mask) : '0);
    end

endmodule

// File: rtl/masked_bit_manip.sv
// Module: masked_bit_manip (top)
// Combinational masked lowest-bit manipulation unit.
// Assumes mode = {merge[1:0], neighbour[1:0], pass_plain}; no clock, no state.
module masked_bit_manip #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            b_is_zero,
    input  logic [4:0]      mode,
    input  logic            restore,
    output logic [XLEN-1:0] result
);
    import mbm_pkg::*;

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] work;
    logic [XLEN-1:0] term_a;
    logic [XLEN-1:0] term_b;
    nbr_sel_e        nbr_sel;
    merge_sel_e      merge_sel;

    // Split the mode word into its fields.
    always_comb begin
        nbr_sel   = nbr_sel_e'(mode[NBR_LO +: 2]);
        merge_sel = merge_sel_e'(mode[MERGE_LO +: 2]);
    end

    mbm_mask_gen #(.XLEN(XLEN)) u_mask (
        .opa       (opa),
        .opb       (opb),
        .b_is_zero (b_is_zero),
        .mask      (mask),
        .work      (work)
    );

    mbm_term_gen #(.XLEN(XLEN)) u_terms (
        .work       (work),
        .mask       (mask),
        .pass_plain (mode[PLAIN_B]),
        .nbr_sel    (nbr_sel),
        .term_a     (term_a),
        .term_b     (term_b)
    );

    mbm_merge #(.XLEN(XLEN)) u_merge (
        .term_a    (term_a),
        .term_b    (term_b),
        .mask      (mask),
        .opa       (opa),
        .merge_sel (merge_sel),
        .restore   (restore),
        .result    (result)
    );

    // Cross-check the sub-block outputs against the port-level rules.
    always_comb begin
        // R1
        mask_full_chk: assert (!b_is_zero || (&mask))
            else $error("mask not full with zero field");
        // R1
        mask_pass_chk: assert (b_is_zero || (mask == opb))
            else $error("mask differs from opb");
        // R6
        term_in_mask_chk: assert (((term_a | term_b) & ~mask) == '0)
            else $error("term bit outside mask");
        // R9
        outside_clear_chk: assert (restore || ((result & ~mask) == '0))
            else $error("result bit outside mask without restore");
        // R10
        outside_keep_chk: assert (!restore || ((result & ~mask) == (opa & ~mask)))
            else $error("outside bits not restored");
        // R8
        undef_zero_chk: assert ((mode[4:3] != 2'd3) || ((result & mask) == '0))
            else $error("merge code 3 not zero");
    end

endmodule

// File: tb/masked_bit_manip_test.sv
module masked_bit_manip_test;

    localparam int XLEN       = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int N_RAND     = 3000;

    logic            clk = 1'b0;
    logic [XLEN-1:0] opa = '0;
    logic [XLEN-1:0] opb = '0;
    logic            b_is_zero = 1'b0;
    logic [4:0]      mode = '0;
    logic            restore = 1'b0;
    logic [XLEN-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    masked_bit_manip #(.XLEN(XLEN)) uut (
        .opa(opa), .opb(opb), .b_is_zero(b_is_zero),
        .mode(mode), .restore(restore), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic logic [XLEN-1:0] ref_model(
        input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
        input logic bz, input logic [4:0] m, input logic rs);
        logic [XLEN-1:0] mk, w, t1, t2, mg;
        mk = bz ? '1 : b;
        w  = a & mk;
        t1 = m[0] ? w : ~w;
        case (m[2:1])
            2'd0: t2 = ~w + 1;
            2'd1: t2 = w - 1;
            2'd2: t2 = w + 1;
            default: t2 = ~(w + 1);
        endcase
        t1 = t1 & mk;
        t2 = t2 & mk;
        case (m[4:3])
            2'd0: mg = t1 | t2;
            2'd1: mg = t1 & t2;
            2'd2: mg = t1 ^ t2;
            default: mg = '0;
        endcase
        return (mg & mk) | (rs ? (a & ~mk) : '0);
    endfunction

    task automatic apply(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                         input logic bz, input logic [4:0] m, input logic rs);
        @(posedge clk);
        opa = a; opb = b; b_is_zero = bz; mode = m; restore = rs;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [XLEN-1:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (opa=%h opb=%h bz=%0b mode=%b rs=%0b)",
                     tag, result, exp, opa, opb, b_is_zero, mode, restore);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] ra, rb;
        logic [XLEN-1:0] keep_first;
        void'($urandom(32'd20240611));

        // Reset-like state: all inputs zero gives a zero result (R9).
        @(negedge clk);
        check("R9 idle", '0);

        // R1: full mask when the field is zero; empty mask from opb=0.
        apply(32'h0000_0010, 32'h0, 1'b1, 5'b00011, 1'b0);
        check("R1 full", 32'h0000_001F);
        apply(32'h0000_FFFF, 32'h0, 1'b0, 5'b00101, 1'b0);
        check("R1 empty", 32'h0);
        apply(32'h0000_FFFF, 32'h0, 1'b0, 5'b00101, 1'b1);
        check("R10 empty", 32'h0000_FFFF);

        // R2: bits of opa outside the mask do not change the in-mask result.
        apply(32'h0030_1200, 32'h0000_FF00, 1'b0, 5'b01001, 1'b0);
        check("R2 a", 32'h0000_0200);
        keep_first = result;
        apply(32'hFFFF_12FF, 32'h0000_FF00, 1'b0, 5'b01001, 1'b0);
        check("R2 b", keep_first);

        // R3: inversion bit.
        apply(32'h0000_0010, 32'h0, 1'b1, 5'b00010, 1'b0);
        check("R3 inv", 32'hFFFF_FFEF);
        apply(32'h0000_0010, 32'h0, 1'b1, 5'b00011, 1'b0);
        check("R3 plain", 32'h0000_001F);

        // R4: each neighbour code, XOR with the plain term.
        apply(32'h0000_0C00, 32'h0, 1'b1, 5'b10001, 1'b0);
        check("R4 neg", 32'hFFFF_F800);
        apply(32'h0000_0C00, 32'h0, 1'b1, 5'b10011, 1'b0);
        check("R4 dec", 32'h0000_07FF);
        apply(32'h0000_0C00, 32'h0, 1'b1, 5'b10101, 1'b0);
        check("R4 inc", 32'h0000_0001);
        apply(32'h0000_0C00, 32'h0, 1'b1, 5'b10111, 1'b0);
        check("R4 notinc", 32'hFFFF_FFFE);

        // R5: wrap at both ends.
        apply(32'h0, 32'h0, 1'b1, 5'b10011, 1'b0);
        check("R5 dec0", 32'hFFFF_FFFF);
        apply(32'hFFFF_FFFF, 32'h0, 1'b1, 5'b10101, 1'b0);
        check("R5 incmax", 32'hFFFF_FFFF);

        // R6: terms masked before merging.
        apply(32'h0000_0003, 32'h0000_000F, 1'b0, 5'b00000, 1'b0);
        check("R6", 32'h0000_000D);

        // R7: AND and OR operators.
        apply(32'h0000_0B40, 32'h0, 1'b1, 5'b01011, 1'b0);
        check("R7 and", 32'h0000_0B00);
        apply(32'h0000_00FF, 32'h0, 1'b1, 5'b00101, 1'b0);
        check("R7 or", 32'h0000_01FF);

        // R8: merge code 3 is zero inside the mask.
        apply(32'h1234_5678, 32'h0, 1'b1, 5'b11001, 1'b0);
        check("R8 full", 32'h0);
        apply(32'h1234_5678, 32'h0000_FFFF, 1'b0, 5'b11110, 1'b1);
        check("R8 restore", 32'h1234_0000);

        // R9 / R10: field edit with and without restore.
        apply(32'hABCD_1237, 32'h0000_00FF, 1'b0, 5'b00101, 1'b0);
        check("R9 field", 32'h0000_003F);
        apply(32'hABCD_1237, 32'h0000_00FF, 1'b0, 5'b00101, 1'b1);
        check("R10 field", 32'hABCD_123F);

        // R11: named idioms.
        apply(32'h0000_0B40, 32'h0, 1'b1, 5'b01001, 1'b0);
        check("R11 isolate", 32'h0000_0040);
        apply(32'h0000_0B40, 32'h0, 1'b1, 5'b01011, 1'b0);
        check("R11 clear", 32'h0000_0B00);
        for (int i = 0; i < 24; i++) begin
            ra = $urandom();
            apply(ra, 32'h0, 1'b1, 5'b00101, 1'b0);
            begin
                logic [XLEN-1:0] e;
                e = ra;
                for (int k = 0; k < XLEN; k++) begin
                    if (!ra[k]) begin
                        e[k] = 1'b1;
                        break;
                    end
                end
                check("R11 setclear", e);
            end
        end

        // Constrained random against the reference model (R7 and all).
        for (int i = 0; i < N_RAND; i++) begin
            ra = $urandom();
            case ($urandom_range(0, 3))
                0: rb = '1 >> $urandom_range(0, XLEN-1);
                1: rb = ('1 >> $urandom_range(0, XLEN-1)) << $urandom_range(0, XLEN-1);
                2: rb = $urandom();
                default: rb = '0;
            endcase
            if ($urandom_range(0, 7) == 0) ra = ra & ~(ra - 1) - 1;
            begin
                logic       bz, rs;
                logic [4:0] m;
                bz = ($urandom_range(0, 3) == 0);
                rs = $urandom_range(0, 1) == 1;
                m  = 5'($urandom_range(0, 31));
                apply(ra, rb, bz, m, rs);
                check("R7 random", ref_model(ra, rb, bz, m, rs));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule